// File: doc/BRIEF.md
# Processor Presence Bitmap with Event Flag

The block keeps one presence bit for each processor, up to a parameterised maximum (256 by default). The bits are packed eight to a byte and read back one byte at a time through a byte read port. A synchronous reset loads the bitmap from a processor count supplied on an input: every processor below that count starts present and every other one starts absent.

A host-side request port carries a processor index and a direction, enable or disable. Each accepted request sets or clears that processor's bit. It also latches a shared change flag inside a small four-byte event block. That block has two status bytes, which software clears by writing ones, and two enable bytes. Bus writes always go to the event block. Bus reads in the bitmap window return bitmap bytes, and reads above that window return event block bytes. An interrupt level is derived from the status and enable bytes, and the change flag is exported on its own for an external interrupt combiner.

Top module: `cpu_presence_map`

## Requirements
- R1: On reset the bitmap byte b is loaded from the count c on `boot_count_i`. It becomes 0xFF when c >= 8b+8, becomes (1<<k)-1 with k = c-8b when 0 < k < 8, and becomes 0x00 otherwise. All four event bytes reset to 0x00.
- R2: Processor n is bit (n mod 8) of bitmap byte n/8. A read at address a < 32 returns bitmap byte a on `rd_data_o`, with no clock delay.
- R3: A request with `req_enable_i`=1 sets the processor's bit, and one with `req_enable_i`=0 clears it. The change is visible from the cycle after the request. No other bitmap bit changes.
- R4: Every accepted request sets bit 2 of event status byte 0, including a request that leaves the bitmap unchanged.
- R5: A read at address a >= 32 returns event byte a[1:0]. Offset 0 is status byte 0, offset 1 is status byte 1, offset 2 is enable byte 0 and offset 3 is enable byte 1.
- R6: A write to a status byte clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R7: A write at any address, including one inside the bitmap window, goes to event byte a[1:0]. An enable byte takes the written value. The bus never changes the bitmap.
- R8: A request whose index is 256 or more is ignored. Neither the bitmap nor the status bytes change.
- R9: When a request and a write that clears status byte 0 bit 2 arrive in the same cycle, the bit ends up set.
- R10: `evt_flag_o` equals status byte 0 bit 2. `irq_o` is 1 exactly when some bit is set in both a status byte and its matching enable byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high; loads the bitmap from the count |
| boot_count_i | input | 9 | Number of processors present at reset (0..256) |
| req_valid_i | input | 1 | Request strobe, one per cycle |
| req_enable_i | input | 1 | 1 = mark present, 0 = mark absent |
| req_index_i | input | 9 | Processor index of the request |
| wr_en_i | input | 1 | Bus byte write strobe |
| wr_addr_i | input | 6 | Bus write address |
| wr_data_i | input | 8 | Bus write data |
| rd_addr_i | input | 6 | Bus read address |
| rd_data_o | output | 8 | Read data for `rd_addr_i` |
| evt_flag_o | output | 1 | Shared processor-change flag |
| irq_o | output | 1 | Interrupt level from status and enable bytes |

## Verification
A wrong bit in the bitmap shows up on `rd_data_o` the cycle after the request that caused it, but only when the bench reads that byte. For this reason the bench reads the touched byte after every request, and it also reads untouched neighbouring bytes. A lost or stuck change flag shows up at once on `evt_flag_o` and on reads of offset 0 of the event block. When the matching enable bit is set, it also shows up on `irq_o`. Preload errors are visible right after reset, and the bench checks full, partial and empty bytes for several counts.

// File: rtl/cpubm_pkg.sv
package cpubm_pkg;
   localparam int BYTE_BITS = 8;

   // Reset value of one bitmap byte whose lowest processor is lo,
   // given a present-processor count cnt.
   function automatic logic [7:0] fill_byte(input int cnt, input int lo);
      int k;
      k = cnt - lo;
      if (k >= BYTE_BITS) return 8'hFF;
      else if (k <= 0) return 8'h00;
      else return 8'((1 << k) - 1);
   endfunction
endpackage

// File: rtl/cpubm_bitmap.sv
module cpubm_bitmap
   import cpubm_pkg::*;
#(
   parameter int NPROC = 256,
   localparam int IDX_W = $clog2(NPROC),
   localparam int CNT_W = IDX_W + 1,
   localparam int NBYTE = NPROC / 8,
   localparam int BSEL_W = IDX_W - 3
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic [CNT_W-1:0] boot_count_i,
   input  logic             acc_i,
   input  logic             on_i,
   input  logic [IDX_W-1:0] idx_i,
   output logic [NPROC-1:0] bits_o
);
   logic [BSEL_W-1:0] byte_sel;
   logic [2:0]        bit_sel;
   assign byte_sel = idx_i[IDX_W-1:3];
   assign bit_sel  = idx_i[2:0];

   for (genvar b = 0; b < NBYTE; b++) begin : gen_byte
      logic [7:0] q;
      logic       hit;
      assign hit = acc_i && (byte_sel == BSEL_W'(b));
      always_ff @(posedge clk_i) begin
         if (rst_i)
            q <= fill_byte(int'(boot_count_i), 8 * b);
         else if (hit)
            q[bit_sel] <= on_i;
      end
      assign bits_o[8*b +: 8] = q;
   end

   p_set_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      (acc_i && on_i) |=> bits_o[$past(idx_i)]);
   p_clr_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      (acc_i && !on_i) |=> !bits_o[$past(idx_i)]);
   p_quiet_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      !acc_i |=> $stable(bits_o));
endmodule

// File: rtl/cpubm_evt_block.sv
module cpubm_evt_block #(
   parameter int EVT_BYTES = 4,
   parameter int EVT_BIT = 2,
   localparam int OFF_W = $clog2(EVT_BYTES),
   localparam int NSTS = EVT_BYTES / 2
) (
   input  logic                   clk_i,
   input  logic                   rst_i,
   input  logic                   hw_set_i,
   input  logic                   wr_en_i,
   input  logic [OFF_W-1:0]       wr_off_i,
   input  logic [7:0]             wr_data_i,
   output logic [EVT_BYTES*8-1:0] bytes_o,
   output logic                   flag_o,
   output logic                   irq_o
);
   logic [7:0] sts_q [NSTS];
   logic [7:0] en_q  [NSTS];

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         for (int s = 0; s < NSTS; s++) begin
            sts_q[s] <= '0;
            en_q[s]  <= '0;
         end
      end else begin
         for (int s = 0; s < NSTS; s++) begin
            logic [7:0] clr_m;
            logic [7:0] set_m;
            clr_m = (wr_en_i && wr_off_i == OFF_W'(s)) ? wr_data_i : 8'h00;
            set_m = (s == 0 && hw_set_i) ? (8'h01 << EVT_BIT) : 8'h00;
            sts_q[s] <= (sts_q[s] & ~clr_m) | set_m;
            if (wr_en_i && wr_off_i == OFF_W'(NSTS + s))
               en_q[s] <= wr_data_i;
         end
      end
   end

   always_comb begin
      irq_o = 1'b0;
      for (int s = 0; s < NSTS; s++) begin
         bytes_o[8*s +: 8]          = sts_q[s];
         bytes_o[8*(NSTS+s) +: 8]   = en_q[s];
         irq_o = irq_o | (|(sts_q[s] & en_q[s]));
      end
   end
   assign flag_o = sts_q[0][EVT_BIT];

   p_set_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      hw_set_i |=> flag_o);
   p_w1c_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      (wr_en_i && wr_off_i == '0 && wr_data_i[EVT_BIT] && !hw_set_i) |=> !flag_o);
   p_hw_wins_r9: assert property (@(posedge clk_i) disable iff (rst_i)
      (hw_set_i && wr_en_i && wr_off_i == '0 && wr_data_i[EVT_BIT]) |=> flag_o);
endmodule

// File: rtl/cpubm_rd_mux.sv
module cpubm_rd_mux #(
   parameter int NPROC = 256,
   parameter int EVT_BYTES = 4,
   parameter int ADDR_W = 6,
   localparam int NBYTE = NPROC / 8,
   localparam int OFF_W = $clog2(EVT_BYTES)
) (
   input  logic [ADDR_W-1:0]      rd_addr_i,
   input  logic [NPROC-1:0]       bits_i,
   input  logic [EVT_BYTES*8-1:0] evt_i,
   output logic [7:0]             rd_data_o
);
   logic [7:0] bm_byte;
   logic [7:0] evt_byte;

   always_comb begin
      bm_byte = 8'h00;
      for (int b = 0; b < NBYTE; b++)
         if (rd_addr_i == ADDR_W'(b)) bm_byte = bits_i[8*b +: 8];
   end

   always_comb begin
      evt_byte = 8'h00;
      for (int e = 0; e < EVT_BYTES; e++)
         if (rd_addr_i[OFF_W-1:0] == OFF_W'(e)) evt_byte = evt_i[8*e +: 8];
   end

   assign rd_data_o = (rd_addr_i < ADDR_W'(NBYTE)) ? bm_byte : evt_byte;
endmodule

// File: rtl/cpu_presence_map.sv
module cpu_presence_map #(
   parameter int NPROC = 256,
   parameter int EVT_BYTES = 4,
   parameter int EVT_BIT = 2,
   localparam int IDX_W = $clog2(NPROC),
   localparam int CNT_W = IDX_W + 1,
   localparam int NBYTE = NPROC / 8,
   localparam int ADDR_W = $clog2(NBYTE) + 1,
   localparam int OFF_W = $clog2(EVT_BYTES)
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic [CNT_W-1:0]  boot_count_i,
   input  logic              req_valid_i,
   input  logic              req_enable_i,
   input  logic [CNT_W-1:0]  req_index_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [7:0]        wr_data_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [7:0]        rd_data_o,
   output logic              evt_flag_o,
   output logic              irq_o
);
   if (NPROC % 8 != 0 || NPROC < 16)
      $error("NPROC must be a multiple of 8 and at least 16");
   if (EVT_BYTES < 2 || EVT_BYTES % 2 != 0 || (1 << OFF_W) != EVT_BYTES)
      $error("EVT_BYTES must be an even power of two");
   if (EVT_BIT < 0 || EVT_BIT > 7)
      $error("EVT_BIT must select a bit of a byte");

   logic                   acc;
   logic [NPROC-1:0]       bits;
   logic [EVT_BYTES*8-1:0] evt_bytes;
   logic                   wr_hi_unused;

   assign acc = req_valid_i && (req_index_i < CNT_W'(NPROC));
   assign wr_hi_unused = ^wr_addr_i[ADDR_W-1:OFF_W];

   cpubm_bitmap #(.NPROC(NPROC)) bitmap_i (
      .clk_i        (clk_i),
      .rst_i        (rst_i),
      .boot_count_i (boot_count_i),
      .acc_i        (acc),
      .on_i         (req_enable_i),
      .idx_i        (req_index_i[IDX_W-1:0]),
      .bits_o       (bits)
   );

   cpubm_evt_block #(.EVT_BYTES(EVT_BYTES), .EVT_BIT(EVT_BIT)) evt_i (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .hw_set_i  (acc),
      .wr_en_i   (wr_en_i),
      .wr_off_i  (wr_addr_i[OFF_W-1:0]),
      .wr_data_i (wr_data_i),
      .bytes_o   (evt_bytes),
      .flag_o    (evt_flag_o),
      .irq_o     (irq_o)
   );

   cpubm_rd_mux #(.NPROC(NPROC), .EVT_BYTES(EVT_BYTES), .ADDR_W(ADDR_W)) rd_i (
      .rd_addr_i (rd_addr_i),
      .bits_i    (bits),
      .evt_i     (evt_bytes),
      .rd_data_o (rd_data_o)
   );

   p_ignore_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      (req_valid_i && req_index_i >= CNT_W'(NPROC) && !wr_en_i)
         |=> ($stable(bits) && $stable(evt_bytes)));
   p_bus_no_bitmap_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      (wr_en_i && !req_valid_i) |=> $stable(bits));
endmodule

// File: tb/cpu_presence_map_tb_top.sv
module cpu_presence_map_tb_top;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [8:0] boot_count = 9'd13;
   logic       req_valid = 1'b0, req_enable = 1'b0;
   logic [8:0] req_index = '0;
   logic       wr_en = 1'b0;
   logic [5:0] wr_addr = '0, rd_addr = '0;
   logic [7:0] wr_data = '0, rd_data;
   logic       evt_flag, irq;
   int total = 0, bad = 0;

   always #10 clk = ~clk;

   cpu_presence_map dut_i (
      .clk_i(clk), .rst_i(rst), .boot_count_i(boot_count),
      .req_valid_i(req_valid), .req_enable_i(req_enable), .req_index_i(req_index),
      .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
      .rd_addr_i(rd_addr), .rd_data_o(rd_data),
      .evt_flag_o(evt_flag), .irq_o(irq)
   );

   // kind: 0 enable req, 1 disable req, 2 bus write, 3 read only
   // fields: kind[32:31] arg[30:22] wdata[21:14] raddr[13:8] expect[7:0]
   localparam logic [32:0] VEC [12] = '{
      {2'd0, 9'd20,  8'h00, 6'd2,  8'h10},  // R3 R2
      {2'd1, 9'd3,   8'h00, 6'd0,  8'hF7},  // R3
      {2'd2, 9'd34,  8'h04, 6'd34, 8'h04},  // R7 R5
      {2'd0, 9'd255, 8'h00, 6'd31, 8'h80},  // R3 R2
      {2'd1, 9'd12,  8'h00, 6'd1,  8'h0F},  // R3
      {2'd2, 9'd5,   8'hFF, 6'd5,  8'h00},  // R7
      {2'd3, 9'd0,   8'h00, 6'd32, 8'h04},  // R4 R5
      {2'd2, 9'd32,  8'h04, 6'd32, 8'h00},  // R6
      {2'd0, 9'd300, 8'h00, 6'd32, 8'h00},  // R8
      {2'd0, 9'd0,   8'h00, 6'd32, 8'h04},  // R4
      {2'd3, 9'd0,   8'h00, 6'd0,  8'hF7},  // R3
      {2'd3, 9'd0,   8'h00, 6'd35, 8'h00}   // R5
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic [8:0] cnt);
      @(negedge clk);
      boot_count = cnt;
      rst = 1'b1;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic step(input logic [1:0] kind, input logic [8:0] arg,
                       input logic [7:0] wd, input logic [5:0] ra);
      @(negedge clk);
      req_valid  = (kind == 2'd0 || kind == 2'd1);
      req_enable = (kind == 2'd0);
      req_index  = arg;
      wr_en      = (kind == 2'd2);
      wr_addr    = arg[5:0];
      wr_data    = wd;
      rd_addr    = ra;
      @(posedge clk);
      #2;
      req_valid = 1'b0;
      wr_en = 1'b0;
      #3;
   endtask

   task automatic rd(input logic [5:0] a, input string req, input logic [7:0] exp);
      @(negedge clk);
      rd_addr = a;
      #2;
      check(req, rd_data, exp);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      do_reset(9'd13);
      rd(6'd0,  "R1 byte0", 8'hFF);
      rd(6'd1,  "R1 byte1", 8'h1F);
      rd(6'd2,  "R1 byte2", 8'h00);
      rd(6'd32, "R1 sts0",  8'h00);
      rd(6'd34, "R1 en0",   8'h00);
      check("R10 flag after reset", {7'd0, evt_flag}, 8'h00);

      foreach (VEC[i]) begin
         step(VEC[i][32:31], VEC[i][30:22], VEC[i][21:14], VEC[i][13:8]);
         check($sformatf("R2-table entry %0d", i), rd_data, VEC[i][7:0]);
      end
      rd(6'd3, "R3 neighbour byte3", 8'h00);

      check("R10 flag set", {7'd0, evt_flag}, 8'h01);
      check("R10 irq set", {7'd0, irq}, 8'h01);

      // R9: clear write and request in the same cycle
      @(negedge clk);
      req_valid = 1'b1; req_enable = 1'b1; req_index = 9'd1;
      wr_en = 1'b1; wr_addr = 6'd32; wr_data = 8'h04;
      @(posedge clk);
      #2;
      req_valid = 1'b0; wr_en = 1'b0;
      rd(6'd32, "R9 hw set wins", 8'h04);

      step(2'd2, 9'd32, 8'h04, 6'd32);
      check("R6 cleared", rd_data, 8'h00);
      check("R10 flag clear", {7'd0, evt_flag}, 8'h00);
      check("R10 irq clear", {7'd0, irq}, 8'h00);

      // R6: writing 0 leaves bit set
      step(2'd0, 9'd9, 8'h00, 6'd32);
      step(2'd2, 9'd32, 8'hFB, 6'd32);
      check("R6 zero bit kept", rd_data, 8'h04);

      do_reset(9'd256);
      rd(6'd31, "R1 full count byte31", 8'hFF);
      do_reset(9'd0);
      rd(6'd0, "R1 zero count byte0", 8'h00);
      do_reset(9'd8);
      rd(6'd0, "R1 count8 byte0", 8'hFF);
      rd(6'd1, "R1 count8 byte1", 8'h00);
      do_reset(9'd250);
      rd(6'd31, "R1 count250 byte31", 8'h03);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule